// File: doc/BRIEF.md
# Synthesizer Control-Word Serial Loader

This block loads the divider and mode settings of an integer-N frequency synthesizer. A serial clock and a serial data line are shared by two shift chains. A select line picks the chain, and a write strobe commits the primary chain. The 21-bit primary chain holds the reference divider R, the main divider M, the swallow counter A, a prescaler enable and an address bit. The 8-bit mode chain holds six control flags. Each chain has its own holding buffer. The outputs change only when a buffer is committed, so the synthesizer never sees a word that is only partly loaded.

The four serial inputs arrive without a clock relation to the system clock. Each passes through a synchronizer, and the block detects edges on the synchronized copies. A small state machine follows the synchronized strobe and select levels and decides which chain each serial clock edge feeds. It has three states. ST_PRI means the strobe is low and the select is low, so edges feed the primary chain. ST_ENH means the strobe is low and the select is high, so edges feed the mode chain. ST_STROBE means the strobe is high, and no chain shifts.

The state machine has six named transitions:
- PRI_TO_ENH: the select rises.
- ENH_TO_PRI: the select falls.
- PRI_TO_STROBE and ENH_TO_STROBE: the strobe rises.
- STROBE_TO_PRI and STROBE_TO_ENH: the strobe falls. The target state follows the select level.

A parallel mode takes every field from input pins instead of the buffers. An active-low enable gates the mode flags.

Top module: `synth_cfg_loader`

## Requirements
- R1: While both `swr_i` and `ewr_i` are low, each rising edge of `sclk_i` shifts `sdata_i` into the 21-bit primary chain. The first bit received ends up in the most significant position.
- R2: On a rising edge of `swr_i`, the primary chain is copied into the primary buffer. Between such edges, the primary outputs do not change while serial bits arrive.
- R3: While `ewr_i` is high and `swr_i` is low, each rising edge of `sclk_i` shifts `sdata_i` into the 8-bit mode chain, first bit into the most significant position. The primary chain is left untouched.
- R4: On a falling edge of `ewr_i`, the mode chain is copied into the mode buffer. Before that edge, the mode outputs keep their old values.
- R5: Number the primary bits B0 (first received) to B20 (last). The fields are:
  - `r_div_o` = {B0, B1, B12, B13, B14, B15}
  - `m_div_o` = {B2, B3, B5 ... B11}
  - `a_div_o` = {B16 ... B19}
  - `pre_en_o` = B4
  - `addr_o` = B20
- R6: Number the mode bits B0 to B7. B0 and B1 are ignored. The flags are:
  - `fp_sel_o` = B2
  - `pwr_dn_o` = B3
  - `cnt_load_o` = B4
  - `msel_o` = B5
  - `fc_sel_o` = B6
  - `ld_dis_o` = B7
- R7: While `enh_n_i` is high, all six mode outputs are 0. While it is low, they show the selected source.
- R8: While `direct_i` is high, the outputs come from the pins:
  - the divider fields and the prescaler enable come from `dir_r_i`, `dir_m_i`, `dir_a_i` and `dir_pre_en_i`;
  - the mode flags come from `dir_ctl_i` = {fp, pd, cload, msel, fc, lddis} (bit 5 down to bit 0);
  - `addr_o` is 0.

  When `direct_i` returns low, the buffered values reappear.
- R9: If more than 21 (or 8) bits are shifted before a commit, only the last 21 (or 8) bits received are committed.
- R10: Rising edges of `sclk_i` while `swr_i` is high shift neither chain.
- R11: A synchronous reset clears both chains and both buffers, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| swr_i | input | 1 | Primary write strobe (asynchronous) |
| ewr_i | input | 1 | Mode chain select (asynchronous) |
| enh_n_i | input | 1 | Mode flag enable, active low |
| direct_i | input | 1 | Parallel mode select |
| dir_r_i | input | 6 | Parallel R divider |
| dir_m_i | input | 9 | Parallel M divider |
| dir_a_i | input | 4 | Parallel A counter |
| dir_pre_en_i | input | 1 | Parallel prescaler enable |
| dir_ctl_i | input | 6 | Parallel mode flags {fp, pd, cload, msel, fc, lddis} |
| r_div_o | output | 6 | R divider |
| m_div_o | output | 9 | M divider |
| a_div_o | output | 4 | A counter |
| pre_en_o | output | 1 | Prescaler enable |
| addr_o | output | 1 | Address bit |
| fp_sel_o | output | 1 | fp output select |
| pwr_dn_o | output | 1 | Power down |
| cnt_load_o | output | 1 | Counter load |
| msel_o | output | 1 | MSEL output select |
| fc_sel_o | output | 1 | fc output select |
| ld_dis_o | output | 1 | Lock-detect disable |

## Verification
The bench walks a single one through all 21 primary positions and all 8 mode positions. A design with a swapped or shifted bit mapping therefore lands the one in the wrong field. Before each commit it checks that the outputs still hold the previous word; a buffer that passes through early would fail there. It shifts in too many bits, which exposes a chain that keeps the oldest bits instead of the newest. It also shifts while the strobe is high and while the mode chain is selected, then commits again; a design that lets those edges reach the primary chain would change the committed word. Finally it toggles the enable and the parallel mode, which catches an ungated flag or an address bit that is not forced to 0.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int PRI_W = 21;
    localparam int ENH_W = 8;
    localparam int CTL_W = 6;

    typedef enum logic [1:0] {
        ST_PRI    = 2'd0,
        ST_ENH    = 2'd1,
        ST_STROBE = 2'd2
    } load_state_e;

    typedef struct packed {
        logic [5:0] r;
        logic [8:0] m;
        logic [3:0] a;
        logic       pre_en;
        logic       addr;
    } pri_fields_t;

    typedef struct packed {
        logic fp_sel;
        logic pwr_dn;
        logic cnt_load;
        logic msel;
        logic fc_sel;
        logic ld_dis;
    } enh_fields_t;

    // The first bit received sits at word[PRI_W-1].
    function automatic pri_fields_t unpack_pri(input logic [PRI_W-1:0] w);
        pri_fields_t f;
        f.r      = {w[20], w[19], w[8:5]};
        f.m      = {w[18], w[17], w[15:9]};
        f.a      = w[4:1];
        f.pre_en = w[16];
        f.addr   = w[0];
        return f;
    endfunction

    // The two bits received first carry no function.
    function automatic enh_fields_t unpack_enh(input logic [ENH_W-1:0] e);
        return enh_fields_t'(e[CTL_W-1:0]);
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
            assign level_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfg_shift_buf.sv
module cfg_shift_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    input  logic         commit,
    output logic [W-1:0] sh_o,
    output logic [W-1:0] buf_o
);
    logic [W-1:0] sh_q;
    logic [W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            buf_q <= '0;
        end else begin
            if (shift_en) sh_q  <= {sh_q[W-2:0], din};
            if (commit)   buf_q <= sh_q;
        end
    end

    assign sh_o  = sh_q;
    assign buf_o = buf_q;
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_i,
    input  logic       sdata_i,
    input  logic       swr_i,
    input  logic       ewr_i,
    input  logic       enh_n_i,
    input  logic       direct_i,
    input  logic [5:0] dir_r_i,
    input  logic [8:0] dir_m_i,
    input  logic [3:0] dir_a_i,
    input  logic       dir_pre_en_i,
    input  logic [5:0] dir_ctl_i,
    output logic [5:0] r_div_o,
    output logic [8:0] m_div_o,
    output logic [3:0] a_div_o,
    output logic       pre_en_o,
    output logic       addr_o,
    output logic       fp_sel_o,
    output logic       pwr_dn_o,
    output logic       cnt_load_o,
    output logic       msel_o,
    output logic       fc_sel_o,
    output logic       ld_dis_o
);
    localparam int N_SER  = 4;
    localparam int I_SCLK = 0;
    localparam int I_DATA = 1;
    localparam int I_SWR  = 2;
    localparam int I_EWR  = 3;

    logic [N_SER-1:0] lvl;
    logic             sclk_p, swr_p, ewr_p;
    logic             sclk_rise, swr_rise, ewr_fall;
    logic             pri_shift, enh_shift;
    logic [PRI_W-1:0] pri_sh, pri_buf;
    logic [ENH_W-1:0] enh_sh, enh_buf;
    load_state_e      state_q, state_d;
    pri_fields_t      pf;
    enh_fields_t      ef;

    cfg_sync #(.STAGES(SYNC_STAGES), .W(N_SER)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ewr_i, swr_i, sdata_i, sclk_i}),
        .level_o (lvl)
    );

    // Previous synchronized levels, used to find edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= 1'b0;
            swr_p  <= 1'b0;
            ewr_p  <= 1'b0;
        end else begin
            sclk_p <= lvl[I_SCLK];
            swr_p  <= lvl[I_SWR];
            ewr_p  <= lvl[I_EWR];
        end
    end

    assign sclk_rise = lvl[I_SCLK] & ~sclk_p;
    assign swr_rise  = lvl[I_SWR]  & ~swr_p;
    assign ewr_fall  = ~lvl[I_EWR] & ewr_p;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PRI;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRI: begin
                if (lvl[I_SWR])      state_d = ST_STROBE;  // PRI_TO_STROBE
                else if (lvl[I_EWR]) state_d = ST_ENH;     // PRI_TO_ENH
            end
            ST_ENH: begin
                if (lvl[I_SWR])       state_d = ST_STROBE; // ENH_TO_STROBE
                else if (!lvl[I_EWR]) state_d = ST_PRI;    // ENH_TO_PRI
            end
            ST_STROBE: begin
                if (!lvl[I_SWR])      state_d = lvl[I_EWR] ? ST_ENH : ST_PRI;
            end
            default: state_d = ST_PRI;
        endcase
    end

    // Output process: steering and field selection
    always_comb begin
        pri_shift = sclk_rise && (state_q == ST_PRI);
        enh_shift = sclk_rise && (state_q == ST_ENH);
        pf = unpack_pri(pri_buf);
        ef = unpack_enh(enh_buf);
        if (direct_i) begin
            pf.r      = dir_r_i;
            pf.m      = dir_m_i;
            pf.a      = dir_a_i;
            pf.pre_en = dir_pre_en_i;
            pf.addr   = 1'b0;
            ef        = enh_fields_t'(dir_ctl_i);
        end
        if (enh_n_i) ef = '0;
        r_div_o    = pf.r;
        m_div_o    = pf.m;
        a_div_o    = pf.a;
        pre_en_o   = pf.pre_en;
        addr_o     = pf.addr;
        fp_sel_o   = ef.fp_sel;
        pwr_dn_o   = ef.pwr_dn;
        cnt_load_o = ef.cnt_load;
        msel_o     = ef.msel;
        fc_sel_o   = ef.fc_sel;
        ld_dis_o   = ef.ld_dis;
    end

    cfg_shift_buf #(.W(PRI_W)) u_pri (
        .clk      (clk),
        .rst      (rst),
        .shift_en (pri_shift),
        .din      (lvl[I_DATA]),
        .commit   (swr_rise),
        .sh_o     (pri_sh),
        .buf_o    (pri_buf)
    );

    cfg_shift_buf #(.W(ENH_W)) u_enh (
        .clk      (clk),
        .rst      (rst),
        .shift_en (enh_shift),
        .din      (lvl[I_DATA]),
        .commit   (ewr_fall),
        .sh_o     (enh_sh),
        .buf_o    (enh_buf)
    );

    // R2
    pri_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !swr_rise |=> $stable(pri_buf));
    // R4
    enh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ewr_fall |=> $stable(enh_buf));
    // R3
    pri_idle_in_enh_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ENH) |=> $stable(pri_sh));
    // R10
    no_shift_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STROBE) |=> ($stable(pri_sh) && $stable(enh_sh)));
    // R8
    direct_addr_chk: assert property (@(posedge clk) disable iff (rst)
        direct_i |-> (addr_o == 1'b0));
    // R7
    enh_gate_chk: assert property (@(posedge clk) disable iff (rst)
        enh_n_i |-> ({fp_sel_o, pwr_dn_o, cnt_load_o, msel_o, fc_sel_o, ld_dis_o} == '0));
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pri_buf == '0 && enh_buf == '0 && pri_sh == '0 && enh_sh == '0));
endmodule

// File: tb/tb_synth_cfg_loader.sv
`timescale 1ns/1ps
module tb_synth_cfg_loader;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       sclk = 1'b0, sdata = 1'b0, swr = 1'b0, ewr = 1'b0;
    logic       enh_n = 1'b0, direct = 1'b0;
    logic [5:0] d_r = '0;
    logic [8:0] d_m = '0;
    logic [3:0] d_a = '0;
    logic       d_pre = 1'b0;
    logic [5:0] d_ctl = '0;
    logic [5:0] r_o;
    logic [8:0] m_o;
    logic [3:0] a_o;
    logic       pre_o, addr_o, fp_o, pd_o, cl_o, ms_o, fc_o, ld_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic ph [0:20];
    logic eh [0:7];
    logic [20:0] pri_now;
    logic [5:0]  enh_now;

    synth_cfg_loader dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .swr_i(swr), .ewr_i(ewr),
        .enh_n_i(enh_n), .direct_i(direct), .dir_r_i(d_r), .dir_m_i(d_m), .dir_a_i(d_a),
        .dir_pre_en_i(d_pre), .dir_ctl_i(d_ctl), .r_div_o(r_o), .m_div_o(m_o),
        .a_div_o(a_o), .pre_en_o(pre_o), .addr_o(addr_o), .fp_sel_o(fp_o),
        .pwr_dn_o(pd_o), .cnt_load_o(cl_o), .msel_o(ms_o), .fc_sel_o(fc_o), .ld_dis_o(ld_o)
    );

    function automatic logic [20:0] pri_out();
        return {r_o, m_o, a_o, pre_o, addr_o};
    endfunction

    function automatic logic [5:0] enh_out();
        return {fp_o, pd_o, cl_o, ms_o, fc_o, ld_o};
    endfunction

    // Expected primary fields from the last 21 bits received (ph[0] oldest).
    function automatic logic [20:0] exp_pri();
        logic [8:0] m;
        m = {ph[2], ph[3], ph[5], ph[6], ph[7], ph[8], ph[9], ph[10], ph[11]};
        return {ph[0], ph[1], ph[12], ph[13], ph[14], ph[15], m,
                ph[16], ph[17], ph[18], ph[19], ph[4], ph[20]};
    endfunction

    function automatic logic [5:0] exp_enh();
        return {eh[2], eh[3], eh[4], eh[5], eh[6], eh[7]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // target: 0 primary history, 1 mode history, 2 none
    task automatic shift_bit(input logic d, input int target);
        sdata = d;
        clks(4);
        sclk = 1'b1;
        clks(4);
        sclk = 1'b0;
        clks(2);
        if (target == 0) begin
            for (int k = 0; k < 20; k++) ph[k] = ph[k+1];
            ph[20] = d;
        end else if (target == 1) begin
            for (int k = 0; k < 7; k++) eh[k] = eh[k+1];
            eh[7] = d;
        end
    endtask

    task automatic send_pri(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i], 0);
    endtask

    task automatic commit_pri();
        swr = 1'b1;
        clks(6);
        swr = 1'b0;
        clks(6);
    endtask

    task automatic shift_enh(input logic [7:0] v);
        ewr = 1'b1;
        clks(4);
        for (int i = 7; i >= 0; i--) shift_bit(v[i], 1);
    endtask

    task automatic drop_ewr();
        ewr = 1'b0;
        clks(6);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 21; k++) ph[k] = 1'b0;
        for (int k = 0; k < 8; k++)  eh[k] = 1'b0;
        clks(4);
        rst = 1'b0;
        clks(4);
        check("R11 primary reset", pri_out(), 0);
        check("R11 mode reset", enh_out(), 0);
        pri_now = '0;

        // R1 R5: walking one through the primary word
        for (int i = 0; i < 21; i++) begin
            send_pri(32'(21'h100000 >> i), 21);
            check("R2 no change before strobe", pri_out(), pri_now);
            commit_pri();
            pri_now = exp_pri();
            check("R5 R1 walking one", pri_out(), pri_now);
        end
        send_pri(32'h155555, 21); commit_pri(); pri_now = exp_pri();
        check("R5 pattern 155555", pri_out(), pri_now);
        send_pri(32'h0AAAAA, 21); commit_pri(); pri_now = exp_pri();
        check("R5 pattern 0AAAAA", pri_out(), pri_now);
        send_pri(32'h1FFFFF, 21); commit_pri(); pri_now = exp_pri();
        check("R5 all ones", pri_out(), pri_now);

        // R9: overlength primary load
        send_pri(32'h1ABCDEF, 25); commit_pri(); pri_now = exp_pri();
        check("R9 last 21 bits kept", pri_out(), pri_now);

        // R6: walking one through the mode word
        enh_now = '0;
        for (int i = 0; i < 8; i++) begin
            shift_enh(8'h80 >> i);
            check("R4 no change before select falls", enh_out(), enh_now);
            drop_ewr();
            enh_now = exp_enh();
            check("R6 mode walking one", enh_out(), enh_now);
        end
        shift_enh(8'h5A); drop_ewr(); enh_now = exp_enh();
        check("R6 pattern 5A", enh_out(), enh_now);

        // R9: overlength mode load (12 bits)
        ewr = 1'b1; clks(4);
        for (int i = 11; i >= 0; i--) shift_bit(logic'((12'hC3A >> i) & 1), 1);
        drop_ewr(); enh_now = exp_enh();
        check("R9 last 8 mode bits kept", enh_out(), enh_now);

        // R3: mode shifting left the primary chain alone
        check("R3 primary outputs kept", pri_out(), pri_now);
        commit_pri();
        check("R3 primary chain untouched", pri_out(), pri_now);

        // R10: serial clocks during strobe are ignored
        swr = 1'b1; clks(6);
        for (int i = 0; i < 5; i++) shift_bit(~ph[20], 2);
        swr = 1'b0; clks(6);
        commit_pri();
        check("R10 no shift while strobe high", pri_out(), pri_now);

        // R7: enable gating
        enh_n = 1'b1; clks(2);
        check("R7 flags gated off", enh_out(), 0);
        enh_n = 1'b0; clks(2);
        check("R7 flags restored", enh_out(), enh_now);

        // R8: parallel mode
        direct = 1'b1;
        d_r = 6'h2D; d_m = 9'h153; d_a = 4'h9; d_pre = 1'b1; d_ctl = 6'h25;
        clks(2);
        check("R8 direct fields", pri_out(), {6'h2D, 9'h153, 4'h9, 1'b1, 1'b0});
        check("R8 direct flags", enh_out(), 6'h25);
        d_r = 6'h12; d_m = 9'h0AC; d_a = 4'h6; d_pre = 1'b0; d_ctl = 6'h1A;
        clks(2);
        check("R8 direct fields 2", pri_out(), {6'h12, 9'h0AC, 4'h6, 1'b0, 1'b0});
        enh_n = 1'b1; clks(2);
        check("R7 direct flags gated", enh_out(), 0);
        enh_n = 1'b0; direct = 1'b0; clks(2);
        check("R8 serial fields back", pri_out(), pri_now);
        check("R8 serial flags back", enh_out(), enh_now);

        // R11: reset clears buffers
        rst = 1'b1; clks(3); rst = 1'b0; clks(3);
        check("R11 primary cleared", pri_out(), 0);
        check("R11 mode cleared", enh_out(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule